// File: doc/BRIEF.md
# Permission-Gated Cache Tag Directory

This block holds the tag side of a set-associative cache. For every way of every set it stores a line address, an allocation bit, a permission state and a lock that a context can own. A requester issues one operation per cycle with a line-aligned address, and the directory answers one cycle later with a match flag, a grant flag, a way number, an address where one applies, and an error flag. The data array and the protocol controller that decides permissions sit outside this block.

Lookups see only ways that are allocated and whose permission is not the absent state. An access is granted by permission and request kind, not by tag match alone. A per-set age tracker picks replacement victims. Successful accesses refresh it, and allocations refresh it when asked to. Allocation takes the lowest-numbered way that is empty or marked absent.

Top module: `tag_dir`

## Requirements
- R1: The set index is `req_addr_i[START_BIT +: log2(SETS)]`, with SETS = CACHE_BYTES / WAYS / LINE_BYTES. SETS must be at least 2. Lines with different index bits never compete for the same ways. Request addresses are line-aligned.
- R2: After reset every way is empty and every age is zero. A presence test reports no match, and an availability test reports available.
- R3: Every operation gives its response on the clock edge after the one that accepts `req_valid_i`. `rsp_valid_o` is high for exactly that one cycle per request. Unknown operation codes set `rsp_err_o`.
- R4: Permission codes are 0 absent, 1 invalid, 2 read-only, 3 read-write and 4 busy. Set-permission (op 6) writes `req_perm_i` to a matching line, or sets the error flag on a miss. A way that is allocated but marked absent is not found by lookups.
- R5: Access (op 0) sets `rsp_hit_o` on a match. It grants the request if the line is read-write, or if the line is read-only and `req_type_i` is load (0) or fetch (2). Store (1) and atomic (3) are never granted on a read-only line. Nothing is granted on invalid or busy lines.
- R6: An access that matches refreshes the line's age whether or not it is granted. Presence test (op 1) refreshes nothing.
- R7: A refresh sets the way's age to 0 and increments every other age in the set, saturating at WAYS-1. The victim is the way with the highest age; on a tie the lowest index wins.
- R8: Availability (op 2) is granted when some way in the set holds the same line address, or when some way is empty or absent. `rsp_way_o` gives the first free way.
- R9: Allocate (op 3) fills the lowest empty-or-absent way. It sets the permission to invalid and clears the lock, and it refreshes the age only when `req_touch_i` is set.
- R10: Allocating a line that is already present, or into a set with no free way, sets the error flag and changes nothing.
- R11: Deallocate (op 4) empties the matching way and clears its lock. On a miss it sets the error flag.
- R12: Victim probe (op 5) on a set with no available way grants and returns the victim's way and line address. If the set has an available way, it sets the error flag and returns address 0.
- R13: Lock set (op 7) records `req_ctx_i` on a present line, and lock clear (op 8) releases it. Lock test (op 9) grants only when the line is locked by `req_ctx_i`. All three set the error flag on a miss.
- R14: Read by index (op 10) uses set = idx / WAYS and way = idx mod WAYS. It returns the line address and grant when the way is allocated with permission read-only, read-write or busy. Otherwise it returns address 0 and no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Operation strobe |
| req_op_i | input | 4 | Operation code |
| req_addr_i | input | ADDR_W | Line-aligned request address |
| req_type_i | input | 2 | Request kind for access |
| req_ctx_i | input | CTX_W | Context for lock operations |
| req_perm_i | input | 3 | Permission written by set-permission |
| req_touch_i | input | 1 | Allocate also refreshes age |
| req_idx_i | input | log2(SETS*WAYS) | Flat index for read-by-index |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_hit_o | output | 1 | Present-line match in the set |
| rsp_grant_o | output | 1 | Operation-specific grant |
| rsp_way_o | output | log2(WAYS) | Way involved |
| rsp_addr_o | output | ADDR_W | Victim or read-back line address |
| rsp_err_o | output | 1 | Operation refused |

## Verification
Each response, including the error flag, is registered and due on the single rising edge after the strobe. The state changes caused by an operation become visible to the next operation issued one cycle later. The bench drives a request on a falling edge and updates its reference model with the operation at that moment. It compares all response fields on the following falling edge, where it also drives the next request, so back-to-back operations see the updated state. An idle falling edge confirms that the response strobe drops after one cycle.

// File: rtl/tag_dir_pkg.sv
package tag_dir_pkg;

  typedef enum logic [2:0] {
    PERM_NP   = 3'd0,
    PERM_INV  = 3'd1,
    PERM_RO   = 3'd2,
    PERM_RW   = 3'd3,
    PERM_BUSY = 3'd4
  } perm_e;

  typedef enum logic [1:0] {
    RQ_LOAD   = 2'd0,
    RQ_STORE  = 2'd1,
    RQ_FETCH  = 2'd2,
    RQ_ATOMIC = 2'd3
  } rq_e;

  typedef enum logic [3:0] {
    OP_ACCESS   = 4'd0,
    OP_PRESENT  = 4'd1,
    OP_AVAIL    = 4'd2,
    OP_ALLOC    = 4'd3,
    OP_DEALLOC  = 4'd4,
    OP_PROBE    = 4'd5,
    OP_SET_PERM = 4'd6,
    OP_LOCK_SET = 4'd7,
    OP_LOCK_CLR = 4'd8,
    OP_LOCK_TST = 4'd9,
    OP_READ_IDX = 4'd10
  } op_e;

endpackage

// File: rtl/tag_dir_search.sv
module tag_dir_search
  import tag_dir_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int TAG_W = 26
) (
  input  logic [WAYS-1:0]            vld_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [WAYS-1:0][2:0]       perm_i,
  input  logic [TAG_W-1:0]           tag_req_i,
  output logic [WAYS-1:0]            hit_vec_o,
  output logic                       hit_o,
  output logic [$clog2(WAYS)-1:0]    hit_way_o,
  output logic                       free_o,
  output logic [$clog2(WAYS)-1:0]    free_way_o,
  output logic                       avail_o
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0] same_vec, free_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign same_vec[w]  = vld_i[w] && (tag_i[w] == tag_req_i);
    assign hit_vec_o[w] = same_vec[w] && (perm_i[w] != PERM_NP);
    assign free_vec[w]  = !vld_i[w] || (perm_i[w] == PERM_NP);
  end

  // lowest index wins
  always_comb begin
    hit_way_o  = '0;
    free_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec_o[w]) hit_way_o  = WAY_W'(w);
      if (free_vec[w])  free_way_o = WAY_W'(w);
    end
  end

  assign hit_o   = |hit_vec_o;
  assign free_o  = |free_vec;
  assign avail_o = free_o | (|same_vec);

endmodule

// File: rtl/tag_dir_lru.sv
module tag_dir_lru #(
  parameter int SETS = 8,
  parameter int WAYS = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      touch_i,
  input  logic [$clog2(SETS)-1:0]   touch_set_i,
  input  logic [$clog2(WAYS)-1:0]   touch_way_i,
  input  logic [$clog2(SETS)-1:0]   rd_set_i,
  output logic [$clog2(WAYS)-1:0]   victim_o
);
  localparam int WAY_W = $clog2(WAYS);
  localparam int AGE_W = $clog2(WAYS);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WAYS - 1);

  logic [SETS-1:0][WAYS-1:0][AGE_W-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q <= '0;
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i)
          age_q[touch_set_i][w] <= '0;
        else if (age_q[touch_set_i][w] != AGE_MAX)
          age_q[touch_set_i][w] <= age_q[touch_set_i][w] + 1'b1;
      end
    end
  end

  logic [AGE_W-1:0] best_age;
  always_comb begin
    victim_o = '0;
    best_age = age_q[rd_set_i][0];
    for (int w = 1; w < WAYS; w++) begin
      if (age_q[rd_set_i][w] > best_age) begin
        best_age = age_q[rd_set_i][w];
        victim_o = WAY_W'(w);
      end
    end
  end

  assert_touch_resets_age_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> age_q[$past(touch_set_i)][$past(touch_way_i)] == '0);

endmodule

// File: rtl/tag_dir.sv
module tag_dir
  import tag_dir_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 64,
  parameter int WAYS        = 4,
  parameter int CACHE_BYTES = 2048,
  parameter int START_BIT   = 6,
  parameter int CTX_W       = 4
) (
  input  logic                                        clk_i,
  input  logic                                        rst_ni,
  input  logic                                        req_valid_i,
  input  logic [3:0]                                  req_op_i,
  input  logic [ADDR_W-1:0]                           req_addr_i,
  input  logic [1:0]                                  req_type_i,
  input  logic [CTX_W-1:0]                            req_ctx_i,
  input  logic [2:0]                                  req_perm_i,
  input  logic                                        req_touch_i,
  input  logic [$clog2(CACHE_BYTES/LINE_BYTES)-1:0]   req_idx_i,
  output logic                                        rsp_valid_o,
  output logic                                        rsp_hit_o,
  output logic                                        rsp_grant_o,
  output logic [$clog2(WAYS)-1:0]                     rsp_way_o,
  output logic [ADDR_W-1:0]                           rsp_addr_o,
  output logic                                        rsp_err_o
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int SETS  = CACHE_BYTES / WAYS / LINE_BYTES;
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int IDX_W = $clog2(SETS * WAYS);

  if (SETS < 2 || WAYS < 2) begin : g_bad_cfg
    $error("tag_dir: needs at least two sets and two ways");
  end

  logic [SETS-1:0][WAYS-1:0]             vld_q, lk_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
  logic [SETS-1:0][WAYS-1:0][2:0]        perm_q;
  logic [SETS-1:0][WAYS-1:0][CTX_W-1:0]  own_q;

  op_e               op;
  logic [SET_W-1:0]  set_idx;
  logic [TAG_W-1:0]  req_tag;
  logic [WAY_W-1:0]  ri_way;
  logic [SET_W-1:0]  ri_set;

  assign op      = op_e'(req_op_i);
  assign set_idx = req_addr_i[START_BIT +: SET_W];
  assign req_tag = req_addr_i[ADDR_W-1:OFF_W];
  assign ri_way  = req_idx_i[WAY_W-1:0];
  assign ri_set  = req_idx_i[IDX_W-1:WAY_W];

  logic [WAYS-1:0]  hit_vec;
  logic             hit, free, avail;
  logic [WAY_W-1:0] hit_way, free_way, victim;

  tag_dir_search #(.WAYS(WAYS), .TAG_W(TAG_W)) u_search (
    .vld_i      (vld_q[set_idx]),
    .tag_i      (tag_q[set_idx]),
    .perm_i     (perm_q[set_idx]),
    .tag_req_i  (req_tag),
    .hit_vec_o  (hit_vec),
    .hit_o      (hit),
    .hit_way_o  (hit_way),
    .free_o     (free),
    .free_way_o (free_way),
    .avail_o    (avail)
  );

  logic             touch, touch_en;
  logic [WAY_W-1:0] touch_way;

  assign touch_way = (op == OP_ACCESS) ? hit_way : free_way;
  assign touch_en  = req_valid_i && touch;

  tag_dir_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (touch_en),
    .touch_set_i (set_idx),
    .touch_way_i (touch_way),
    .rd_set_i    (set_idx),
    .victim_o    (victim)
  );

  logic [2:0] hit_perm, ri_perm;
  logic       ri_live;
  assign hit_perm = perm_q[set_idx][hit_way];
  assign ri_perm  = perm_q[ri_set][ri_way];
  assign ri_live  = vld_q[ri_set][ri_way] &&
                    (ri_perm == PERM_RO || ri_perm == PERM_RW || ri_perm == PERM_BUSY);

  logic              n_hit, n_grant, n_err;
  logic [WAY_W-1:0]  n_way;
  logic [ADDR_W-1:0] n_addr;
  logic do_alloc, do_dealloc, do_perm, do_lkset, do_lkclr;

  always_comb begin
    n_hit      = hit;
    n_grant    = 1'b0;
    n_err      = 1'b0;
    n_way      = hit_way;
    n_addr     = '0;
    do_alloc   = 1'b0;
    do_dealloc = 1'b0;
    do_perm    = 1'b0;
    do_lkset   = 1'b0;
    do_lkclr   = 1'b0;
    touch      = 1'b0;
    case (op)
      OP_ACCESS: begin
        touch   = hit;
        n_grant = hit && (hit_perm == PERM_RW ||
                  (hit_perm == PERM_RO &&
                   (req_type_i == RQ_LOAD || req_type_i == RQ_FETCH)));
      end
      OP_PRESENT: n_grant = hit;
      OP_AVAIL: begin
        n_way   = free_way;
        n_grant = avail;
      end
      OP_ALLOC: begin
        n_way = free_way;
        if (hit || !free) n_err = 1'b1;
        else begin
          do_alloc = 1'b1;
          n_grant  = 1'b1;
          touch    = req_touch_i;
        end
      end
      OP_DEALLOC: begin
        do_dealloc = hit;
        n_grant    = hit;
        n_err      = !hit;
      end
      OP_PROBE: begin
        n_way = victim;
        if (avail) n_err = 1'b1;
        else begin
          n_grant = 1'b1;
          n_addr  = {tag_q[set_idx][victim], {OFF_W{1'b0}}};
        end
      end
      OP_SET_PERM: begin
        do_perm = hit;
        n_grant = hit;
        n_err   = !hit;
      end
      OP_LOCK_SET: begin
        do_lkset = hit;
        n_grant  = hit;
        n_err    = !hit;
      end
      OP_LOCK_CLR: begin
        do_lkclr = hit;
        n_grant  = hit;
        n_err    = !hit;
      end
      OP_LOCK_TST: begin
        n_grant = hit && lk_q[set_idx][hit_way] && (own_q[set_idx][hit_way] == req_ctx_i);
        n_err   = !hit;
      end
      OP_READ_IDX: begin
        n_hit   = 1'b0;
        n_way   = ri_way;
        n_grant = ri_live;
        n_addr  = ri_live ? {tag_q[ri_set][ri_way], {OFF_W{1'b0}}} : '0;
      end
      default: n_err = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      lk_q   <= '0;
      tag_q  <= '0;
      perm_q <= '0;
      own_q  <= '0;
    end else if (req_valid_i) begin
      if (do_alloc) begin
        vld_q[set_idx][free_way]  <= 1'b1;
        tag_q[set_idx][free_way]  <= req_tag;
        perm_q[set_idx][free_way] <= PERM_INV;
        lk_q[set_idx][free_way]   <= 1'b0;
      end
      if (do_dealloc) begin
        vld_q[set_idx][hit_way] <= 1'b0;
        lk_q[set_idx][hit_way]  <= 1'b0;
      end
      if (do_perm)  perm_q[set_idx][hit_way] <= req_perm_i;
      if (do_lkset) begin
        lk_q[set_idx][hit_way]  <= 1'b1;
        own_q[set_idx][hit_way] <= req_ctx_i;
      end
      if (do_lkclr) lk_q[set_idx][hit_way] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_grant_o <= 1'b0;
      rsp_way_o   <= '0;
      rsp_addr_o  <= '0;
      rsp_err_o   <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_hit_o   <= n_hit;
        rsp_grant_o <= n_grant;
        rsp_way_o   <= n_way;
        rsp_addr_o  <= n_addr;
        rsp_err_o   <= n_err;
      end
    end
  end

  assert_line_aligned_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> req_addr_i[OFF_W-1:0] == '0);

  assert_rsp_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o == $past(req_valid_i));

  assert_alloc_writes_invalid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == OP_ALLOC && !hit && free) |=>
      (vld_q[$past(set_idx)][$past(free_way)] &&
       perm_q[$past(set_idx)][$past(free_way)] == PERM_INV &&
       !lk_q[$past(set_idx)][$past(free_way)]));

  assert_unique_match_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> $onehot0(hit_vec));

  assert_dealloc_empties_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == OP_DEALLOC && hit) |=>
      !vld_q[$past(set_idx)][$past(hit_way)]);

endmodule

// File: tb/sim_tag_dir.sv
module sim_tag_dir;
  localparam int CLK_P       = 10;
  localparam int ADDR_W      = 32;
  localparam int LINE_BYTES  = 64;
  localparam int WAYS        = 4;
  localparam int CACHE_BYTES = 2048;
  localparam int START_BIT   = 6;
  localparam int CTX_W       = 4;
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int SETS  = CACHE_BYTES / WAYS / LINE_BYTES;
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int IDX_W = $clog2(SETS * WAYS);

  localparam int O_ACC = 0, O_PRS = 1, O_AVL = 2, O_ALC = 3, O_DAL = 4, O_PRB = 5,
                 O_SPM = 6, O_LKS = 7, O_LKC = 8, O_LKT = 9, O_RDX = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic [3:0] req_op_i = '0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [1:0] req_type_i = '0;
  logic [CTX_W-1:0] req_ctx_i = '0;
  logic [2:0] req_perm_i = '0;
  logic req_touch_i = 1'b0;
  logic [IDX_W-1:0] req_idx_i = '0;
  logic rsp_valid_o, rsp_hit_o, rsp_grant_o, rsp_err_o;
  logic [WAY_W-1:0] rsp_way_o;
  logic [ADDR_W-1:0] rsp_addr_o;

  always #(CLK_P/2) clk_i = ~clk_i;

  tag_dir #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .WAYS(WAYS), .CACHE_BYTES(CACHE_BYTES),
            .START_BIT(START_BIT), .CTX_W(CTX_W)) u0 (
    .clk_i, .rst_ni, .req_valid_i, .req_op_i, .req_addr_i, .req_type_i, .req_ctx_i,
    .req_perm_i, .req_touch_i, .req_idx_i, .rsp_valid_o, .rsp_hit_o, .rsp_grant_o,
    .rsp_way_o, .rsp_addr_o, .rsp_err_o);

  int n_vec = 0, n_bad = 0;

  bit               m_vld [SETS][WAYS];
  logic [TAG_W-1:0] m_tag [SETS][WAYS];
  int               m_perm[SETS][WAYS];
  bit               m_lk  [SETS][WAYS];
  int               m_own [SETS][WAYS];
  int               m_age [SETS][WAYS];

  function automatic logic [ADDR_W-1:0] mk(int hi, int s);
    return (ADDR_W'(hi) << (START_BIT + SET_W)) | (ADDR_W'(s) << START_BIT);
  endfunction

  function automatic int m_hit_way(int s, logic [TAG_W-1:0] t);
    for (int w = 0; w < WAYS; w++)
      if (m_vld[s][w] && m_perm[s][w] != 0 && m_tag[s][w] == t) return w;
    return -1;
  endfunction

  function automatic int m_free_way(int s);
    for (int w = 0; w < WAYS; w++)
      if (!m_vld[s][w] || m_perm[s][w] == 0) return w;
    return -1;
  endfunction

  function automatic bit m_avail(int s, logic [TAG_W-1:0] t);
    for (int w = 0; w < WAYS; w++)
      if (!m_vld[s][w] || m_perm[s][w] == 0 || m_tag[s][w] == t) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int m_victim(int s);
    int v = 0;
    for (int w = 1; w < WAYS; w++) if (m_age[s][w] > m_age[s][v]) v = w;
    return v;
  endfunction

  task automatic m_touch(int s, int w);
    for (int j = 0; j < WAYS; j++)
      if (j == w) m_age[s][j] = 0;
      else if (m_age[s][j] < WAYS - 1) m_age[s][j]++;
  endtask

  task automatic chk(input bit ok, input string tag, input string what);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  // drive at a falling edge, compare at the next falling edge
  task automatic apply(input int op, input logic [ADDR_W-1:0] a, input int typ, input int ctx,
                       input int perm, input bit touch, input int idx, input string tag);
    int s, hw, fw, vw, rs, rw;
    logic [TAG_W-1:0] t;
    bit av, live, e_hit, e_grant, e_err;
    int e_way;
    logic [ADDR_W-1:0] e_addr;
    s  = int'(a[START_BIT +: SET_W]);
    t  = a[ADDR_W-1:OFF_W];
    hw = m_hit_way(s, t);
    fw = m_free_way(s);
    av = m_avail(s, t);
    vw = m_victim(s);
    e_hit = (hw >= 0); e_grant = 0; e_err = 0; e_addr = '0;
    e_way = (hw >= 0) ? hw : 0;
    case (op)
      O_ACC: begin
        if (e_hit) begin
          e_grant = (m_perm[s][hw] == 3) || (m_perm[s][hw] == 2 && (typ == 0 || typ == 2));
          m_touch(s, hw);
        end
      end
      O_PRS: e_grant = e_hit;
      O_AVL: begin e_way = (fw >= 0) ? fw : 0; e_grant = av; end
      O_ALC: begin
        e_way = (fw >= 0) ? fw : 0;
        if (e_hit || fw < 0) e_err = 1;
        else begin
          m_vld[s][fw] = 1; m_tag[s][fw] = t; m_perm[s][fw] = 1; m_lk[s][fw] = 0;
          e_grant = 1;
          if (touch) m_touch(s, fw);
        end
      end
      O_DAL: begin
        if (e_hit) begin m_vld[s][hw] = 0; m_lk[s][hw] = 0; e_grant = 1; end
        else e_err = 1;
      end
      O_PRB: begin
        e_way = vw;
        if (av) e_err = 1;
        else begin e_grant = 1; e_addr = {m_tag[s][vw], {OFF_W{1'b0}}}; end
      end
      O_SPM: begin
        if (e_hit) begin m_perm[s][hw] = perm; e_grant = 1; end else e_err = 1;
      end
      O_LKS: begin
        if (e_hit) begin m_lk[s][hw] = 1; m_own[s][hw] = ctx; e_grant = 1; end else e_err = 1;
      end
      O_LKC: begin
        if (e_hit) begin m_lk[s][hw] = 0; e_grant = 1; end else e_err = 1;
      end
      O_LKT: begin
        if (e_hit) e_grant = m_lk[s][hw] && (m_own[s][hw] == ctx); else e_err = 1;
      end
      O_RDX: begin
        rs = idx / WAYS; rw = idx % WAYS;
        e_hit = 0; e_way = rw;
        live = m_vld[rs][rw] && (m_perm[rs][rw] >= 2);
        e_grant = live;
        e_addr = live ? {m_tag[rs][rw], {OFF_W{1'b0}}} : '0;
      end
      default: e_err = 1;
    endcase
    req_valid_i = 1'b1; req_op_i = 4'(op); req_addr_i = a; req_type_i = 2'(typ);
    req_ctx_i = CTX_W'(ctx); req_perm_i = 3'(perm); req_touch_i = touch; req_idx_i = IDX_W'(idx);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    n_vec++;
    if (rsp_valid_o !== 1'b1 || rsp_hit_o !== e_hit || rsp_grant_o !== e_grant ||
        rsp_err_o !== e_err || rsp_way_o !== WAY_W'(e_way) || rsp_addr_o !== e_addr) begin
      n_bad++;
      $display("FAIL %s op=%0d addr=%h: got v%b h%b g%b e%b w%0d a%h exp v1 h%b g%b e%b w%0d a%h",
               tag, op, a, rsp_valid_o, rsp_hit_o, rsp_grant_o, rsp_err_o, rsp_way_o, rsp_addr_o,
               e_hit, e_grant, e_err, e_way, e_addr);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL R3: watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] a_l, b_l, c_l, d_l, e_l, f_l;
    void'($urandom(32'd4242));
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_vld[s][w] = 0; m_tag[s][w] = '0; m_perm[s][w] = 0;
        m_lk[s][w] = 0; m_own[s][w] = 0; m_age[s][w] = 0;
      end
    a_l = mk(1, 0); b_l = mk(2, 0); c_l = mk(3, 0); d_l = mk(4, 0); e_l = mk(5, 0); f_l = mk(1, 1);

    repeat (3) @(negedge clk_i);
    chk(rsp_valid_o === 1'b0 && rsp_grant_o === 1'b0 && rsp_addr_o === '0, "R2",
        $sformatf("reset outputs v%b g%b a%h exp 0", rsp_valid_o, rsp_grant_o, rsp_addr_o));
    rst_ni = 1'b1;
    @(negedge clk_i);

    apply(O_PRS, a_l, 0, 0, 0, 0, 0, "R2");
    apply(O_AVL, a_l, 0, 0, 0, 0, 0, "R2");
    apply(O_ALC, a_l, 0, 0, 0, 1, 0, "R9");
    apply(O_ALC, a_l, 0, 0, 0, 1, 0, "R10");
    apply(O_ACC, a_l, 0, 0, 0, 0, 0, "R5");
    apply(O_SPM, a_l, 0, 0, 2, 0, 0, "R4");
    apply(O_ACC, a_l, 1, 0, 0, 0, 0, "R5");
    apply(O_ACC, a_l, 3, 0, 0, 0, 0, "R5");
    apply(O_ACC, a_l, 0, 0, 0, 0, 0, "R5");
    apply(O_ACC, a_l, 2, 0, 0, 0, 0, "R5");
    apply(O_SPM, a_l, 0, 0, 3, 0, 0, "R4");
    apply(O_ACC, a_l, 1, 0, 0, 0, 0, "R5");
    @(negedge clk_i);
    chk(rsp_valid_o === 1'b0, "R3", $sformatf("idle strobe got %b exp 0", rsp_valid_o));
    apply(O_ALC, b_l, 0, 0, 0, 0, 0, "R9");
    apply(O_ALC, c_l, 0, 0, 0, 1, 0, "R9");
    apply(O_ALC, d_l, 0, 0, 0, 0, 0, "R9");
    apply(O_PRB, b_l, 0, 0, 0, 0, 0, "R12");
    apply(O_AVL, e_l, 0, 0, 0, 0, 0, "R8");
    apply(O_AVL, c_l, 0, 0, 0, 0, 0, "R8");
    apply(O_ALC, e_l, 0, 0, 0, 0, 0, "R10");
    apply(O_PRS, c_l, 0, 0, 0, 0, 0, "R6");
    apply(O_PRB, e_l, 0, 0, 0, 0, 0, "R12");
    apply(O_ACC, b_l, 1, 0, 0, 0, 0, "R6");
    apply(O_PRB, e_l, 0, 0, 0, 0, 0, "R7");
    apply(O_ALC, f_l, 0, 0, 0, 1, 0, "R1");
    apply(O_PRS, f_l, 0, 0, 0, 0, 0, "R1");
    apply(O_PRS, mk(1, 2), 0, 0, 0, 0, 0, "R1");
    apply(O_SPM, b_l, 0, 0, 0, 0, 0, "R4");
    apply(O_PRS, b_l, 0, 0, 0, 0, 0, "R4");
    apply(O_ACC, b_l, 3, 0, 0, 0, 0, "R4");
    apply(O_AVL, e_l, 0, 0, 0, 0, 0, "R8");
    apply(O_ALC, e_l, 0, 0, 0, 1, 0, "R9");
    apply(O_LKS, a_l, 0, 3, 0, 0, 0, "R13");
    apply(O_LKT, a_l, 0, 3, 0, 0, 0, "R13");
    apply(O_LKT, a_l, 0, 4, 0, 0, 0, "R13");
    apply(O_LKC, a_l, 0, 3, 0, 0, 0, "R13");
    apply(O_LKT, a_l, 0, 3, 0, 0, 0, "R13");
    apply(O_LKS, mk(6, 0), 0, 3, 0, 0, 0, "R13");
    apply(O_SPM, c_l, 0, 0, 4, 0, 0, "R4");
    for (int i = 0; i < WAYS * 2; i++) apply(O_RDX, '0, 0, 0, 0, 0, i, "R14");
    apply(O_DAL, c_l, 0, 0, 0, 0, 0, "R11");
    apply(O_PRS, c_l, 0, 0, 0, 0, 0, "R11");
    apply(O_DAL, c_l, 0, 0, 0, 0, 0, "R11");
    apply(O_RDX, '0, 0, 0, 0, 0, 2, "R14");
    apply(O_PRB, c_l, 0, 0, 0, 0, 0, "R12");
    apply(15, a_l, 0, 0, 0, 0, 0, "R3");

    for (int i = 0; i < 4000; i++) begin
      int op, s, hi;
      logic [ADDR_W-1:0] a;
      s  = ($urandom_range(0, 9) == 0) ? $urandom_range(0, SETS - 1) : $urandom_range(0, 1);
      hi = $urandom_range(0, 5);
      a  = mk(hi, s);
      op = $urandom_range(0, 13);
      if (op > 10) op = O_ALC;
      apply(op, a, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 4),
            1'($urandom_range(0, 1)), $urandom_range(0, SETS * WAYS - 1), "R7");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule